// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds one 8-bit control/status register for each DMA channel. It sits on a simple byte-wide register bus. Software can write a whole byte or a single addressed bit, and it can read a whole byte. Each register has four parts:

- an enable level, which the block drives straight to that channel's transfer engine;
- a start command, which becomes a one-clock pulse to the engine;
- an initialise command, which also becomes a one-clock pulse;
- a completion flag, which only hardware sets.

When the engine reports a terminal count, the block drops the enable at once. It raises the completion flag on the following clock edge, and a software read clears the flag. The start command acts only when the channel is enabled and not yet complete. The initialise command acts only when the channel is disabled. In any other state the command does nothing.

The register bus is a plain control interface with no back-pressure. A write takes effect in the cycle it is presented, and every read is accepted. Read data comes back one cycle after the read request, marked by a one-cycle valid pulse. If a byte write and a bit write arrive in the same cycle, the byte write is used. A read may arrive in the same cycle as a write.

Top module: `dma_chan_ctl_bank`

## Requirements
- R1: After reset every channel reads 0x00, and all outputs are 0: `chan_en`, `start_pulse`, `init_pulse`, `rd_data` and `rd_valid`.
- R2: Bit positions are fixed. Bit 0 is enable, bit 1 is start and bit 2 is initialise; these are the command bits. Bit 7 is the completion flag. A read returns {flag, 6'b0, enable}, so bits 6 to 1 always read 0.
- R3: A byte write sets the channel's enable to write-data bit 0. Write-data bit 7 and bits 6 to 3 have no effect.
- R4: A single-bit write with index `bit_idx` and value `bit_val` affects only the addressed bit. Index 0 sets enable to `bit_val`. Index 1 or 2 with value 1 issues start or initialise. Indices 3 to 7 change nothing.
- R5: A start command produces a one-clock `start_pulse` in the cycle after the write. It does so only if, before the write, enable was 1 and the flag was 0. Otherwise no pulse appears.
- R6: An initialise command produces a one-clock `init_pulse` in the cycle after the write. It does so only if enable was 0 before the write.
- R7: A `tc_in` pulse clears enable on the clock edge that samples it, and sets the flag on the next edge. A read sampled on that next edge returns 0x00.
- R8: A read clears the flag. If a read and the flag-setting edge coincide, setting wins, so the next read returns the flag as 1.
- R9: `rd_data` and `rd_valid` update one cycle after `rd_en`. `rd_valid` is high for exactly one cycle per read, and `rd_data` holds its value between reads.
- R10: A terminal count overrides an enable write to the same channel in the same cycle, so enable ends as 0.
- R11: Accesses and terminal counts for one channel leave every other channel's register and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Channel select |
| wr_byte | input | 1 | Byte write request |
| wr_data | input | 8 | Byte write data |
| wr_bit | input | 1 | Single-bit write request |
| bit_idx | input | 3 | Bit index for a single-bit write |
| bit_val | input | 1 | Bit value for a single-bit write |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Read data valid pulse |
| tc_in | input | 4 | Terminal-count pulse from each channel's engine |
| chan_en | output | 4 | Enable level to each engine |
| start_pulse | output | 4 | One-clock start pulse to each engine |
| init_pulse | output | 4 | One-clock initialise pulse to each engine |

## Verification
A wrong enable bit is visible on `chan_en` in the cycle right after the access that caused it. A wrong completion flag stays hidden until the next read, where it shows in `rd_data` bit 7. A wrong flag also shows up earlier as a missing or spurious `start_pulse`, because the flag gates start commands. The bench therefore sweeps every write byte and every single-bit write across all four enable/flag states on every channel. After each access it checks the enable vector and the pulse vectors one cycle later, and then reads the register back. The intermediate read after a terminal count and a repeat read then confirm the two-step update order and the rule that setting the flag wins over a read.

// File: rtl/dmacs_pkg.sv
package dmacs_pkg;
  localparam int REG_W     = 8;
  localparam int IDX_W     = 3;
  localparam int BIT_EN    = 0;
  localparam int BIT_START = 1;
  localparam int BIT_INIT  = 2;
  localparam int BIT_FLAG  = 7;

  typedef struct packed {
    logic             byte_we;
    logic             bit_we;
    logic [REG_W-1:0] data;
    logic [IDX_W-1:0] idx;
    logic             bval;
  } wr_cmd_t;
endpackage

// File: rtl/dmacs_decode.sv
module dmacs_decode #(
  parameter int NUM_CH = 4,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_byte,
  input  logic              wr_bit,
  input  logic              rd_en,
  output logic [NUM_CH-1:0] byte_sel,
  output logic [NUM_CH-1:0] bit_sel,
  output logic [NUM_CH-1:0] rd_sel
);
  logic bit_ok;
  assign bit_ok = wr_bit & ~wr_byte;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    logic hit;
    assign hit         = (addr == AW'(i));
    assign byte_sel[i] = hit & wr_byte;
    assign bit_sel[i]  = hit & bit_ok;
    assign rd_sel[i]   = hit & rd_en;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_sel | bit_sel)); // R11
  AST_BYTE_OVER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |-> (bit_sel == '0)); // R4
endmodule

// File: rtl/dmacs_chan.sv
module dmacs_chan
  import dmacs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  wr_cmd_t cmd,
  input  logic rd_hit,
  input  logic tc_in,
  output logic en_o,
  output logic flag_o,
  output logic start_o,
  output logic init_o
);
  logic en_q, flag_q, pend_q, start_q, init_q;
  logic en_wr, en_wval, start_req, init_req;
  logic en_d, flag_d, start_d, init_d;

  always_comb begin
    en_wr     = cmd.byte_we | (cmd.bit_we && cmd.idx == IDX_W'(BIT_EN));
    en_wval   = cmd.byte_we ? cmd.data[BIT_EN] : cmd.bval;
    start_req = cmd.byte_we ? cmd.data[BIT_START]
                            : (cmd.bit_we && cmd.idx == IDX_W'(BIT_START) && cmd.bval);
    init_req  = cmd.byte_we ? cmd.data[BIT_INIT]
                            : (cmd.bit_we && cmd.idx == IDX_W'(BIT_INIT) && cmd.bval);
    if (tc_in)      en_d = 1'b0;
    else if (en_wr) en_d = en_wval;
    else            en_d = en_q;
    if (pend_q)      flag_d = 1'b1;
    else if (rd_hit) flag_d = 1'b0;
    else             flag_d = flag_q;
    start_d = start_req & en_q & ~flag_q;
    init_d  = init_req & ~en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      flag_q  <= flag_d;
      pend_q  <= tc_in;
      start_q <= start_d;
      init_q  <= init_d;
    end
  end

  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign start_o = start_q;
  assign init_o  = init_q;

  AST_TC_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tc_in |=> !en_q); // R7
  AST_FLAG_FOLLOWS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    tc_in |=> ##1 flag_q); // R7
  AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(en_q) && !$past(flag_q))); // R5
  AST_INIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> !$past(en_q)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !pend_q) |=> !flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && pend_q) |=> flag_q); // R8
endmodule

// File: rtl/dmacs_rdmux.sv
module dmacs_rdmux
  import dmacs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [NUM_CH-1:0] en_vec,
  input  logic [NUM_CH-1:0] flag_vec,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == AW'(i)) begin
        word[BIT_EN]   = en_vec[i];
        word[BIT_FLAG] = flag_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_FLAG-1:BIT_EN+1] == '0); // R2
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: rtl/dma_chan_ctl_bank.sv
module dma_chan_ctl_bank
  import dmacs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              wr_byte,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wr_bit,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid,
  input  logic [NUM_CH-1:0] tc_in,
  output logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] start_pulse,
  output logic [NUM_CH-1:0] init_pulse
);
  logic [NUM_CH-1:0] byte_sel, bit_sel, rd_sel, flag_vec;

  dmacs_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_byte(wr_byte),
    .wr_bit(wr_bit), .rd_en(rd_en), .byte_sel(byte_sel),
    .bit_sel(bit_sel), .rd_sel(rd_sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    wr_cmd_t cmd;
    assign cmd.byte_we = byte_sel[i];
    assign cmd.bit_we  = bit_sel[i];
    assign cmd.data    = wr_data;
    assign cmd.idx     = bit_idx;
    assign cmd.bval    = bit_val;

    dmacs_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .rd_hit(rd_sel[i]),
      .tc_in(tc_in[i]), .en_o(chan_en[i]), .flag_o(flag_vec[i]),
      .start_o(start_pulse[i]), .init_o(init_pulse[i])
    );
  end

  dmacs_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(reg_addr),
    .en_vec(chan_en), .flag_vec(flag_vec), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  AST_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_byte && !wr_bit && tc_in == '0) |=> $stable(chan_en)); // R11
  AST_PULSES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse)); // R11
endmodule

// File: tb/dma_chan_ctl_bank_bench.sv
module dma_chan_ctl_bank_bench;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic wr_byte = 0, wr_bit = 0, bit_val = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] bit_idx = 0;
  logic [N-1:0] tc_in = 0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [N-1:0] chan_en, start_pulse, init_pulse;

  int n_chk = 0, n_err = 0;
  logic [N-1:0] m_en = 0, m_fl = 0;

  always #10 clk = ~clk;

  dma_chan_ctl_bank u_dma_chan_ctl_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_byte(wr_byte),
    .wr_data(wr_data), .wr_bit(wr_bit), .bit_idx(bit_idx), .bit_val(bit_val),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .tc_in(tc_in),
    .chan_en(chan_en), .start_pulse(start_pulse), .init_pulse(init_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet_edge();
    @(negedge clk);
    wr_byte = 0; wr_bit = 0; rd_en = 0; tc_in = '0;
    @(posedge clk); #1;
    check("R5 start pulse width", start_pulse, 0);
    check("R6 init pulse width", init_pulse, 0);
  endtask

  task automatic do_byte(input int ch, input logic [7:0] v);
    logic s, in;
    @(negedge clk);
    reg_addr = ch[1:0]; wr_byte = 1; wr_data = v;
    s = v[1] & m_en[ch] & ~m_fl[ch];
    in = v[2] & ~m_en[ch];
    m_en[ch] = v[0];
    @(posedge clk); #1;
    check("R5 start after byte write", start_pulse, N'(s) << ch);
    check("R6 init after byte write", init_pulse, N'(in) << ch);
    check("R3/R11 enable after byte write", chan_en, m_en);
    quiet_edge();
  endtask

  task automatic do_bit(input int ch, input int idx, input logic val);
    logic s, in;
    @(negedge clk);
    reg_addr = ch[1:0]; wr_bit = 1; bit_idx = idx[2:0]; bit_val = val;
    s = (idx == 1) & val & m_en[ch] & ~m_fl[ch];
    in = (idx == 2) & val & ~m_en[ch];
    if (idx == 0) m_en[ch] = val;
    @(posedge clk); #1;
    check("R4/R5 start after bit write", start_pulse, N'(s) << ch);
    check("R4/R6 init after bit write", init_pulse, N'(in) << ch);
    check("R4/R11 enable after bit write", chan_en, m_en);
    quiet_edge();
  endtask

  task automatic do_read(input int ch);
    @(negedge clk);
    reg_addr = ch[1:0]; rd_en = 1;
    @(posedge clk); #1;
    check("R9 read valid", rd_valid, 1);
    check("R2/R8 read data", rd_data, {m_fl[ch], 6'b0, m_en[ch]});
    m_fl[ch] = 0;
    @(negedge clk); rd_en = 0;
    @(posedge clk); #1;
    check("R9 valid one cycle", rd_valid, 0);
  endtask

  task automatic tc_pulse(input int ch);
    @(negedge clk); tc_in[ch] = 1;
    @(posedge clk); #1;
    m_en[ch] = 0;
    check("R7 enable cleared by tc", chan_en, m_en);
    @(negedge clk); tc_in = '0;
    @(posedge clk); #1;
    m_fl[ch] = 1;
  endtask

  task automatic set_state(input int ch, input int st);
    if (m_fl[ch]) do_read(ch);
    if (st[1]) tc_pulse(ch);
    do_bit(ch, 0, st[0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset chan_en", chan_en, 0);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset rd_valid", rd_valid, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 start after reset", start_pulse, 0);
    check("R1 init after reset", init_pulse, 0);
    for (int ch = 0; ch < N; ch++) do_read(ch);

    for (int ch = 0; ch < N; ch++) begin
      // R7 / R8: intermediate read returns 0, setting wins, then clear on read
      do_byte(ch, 8'h01);
      @(negedge clk); tc_in[ch] = 1;
      @(posedge clk); #1;
      m_en[ch] = 0;
      check("R7 enable dropped", chan_en, m_en);
      @(negedge clk); tc_in = '0; reg_addr = ch[1:0]; rd_en = 1;
      @(posedge clk); #1;
      check("R7 intermediate read", rd_data, 8'h00);
      m_fl[ch] = 1;
      @(negedge clk); rd_en = 0;
      do_read(ch);
      do_read(ch);
      // R10: tc beats same-cycle enable write
      @(negedge clk); tc_in[ch] = 1; reg_addr = ch[1:0]; wr_byte = 1; wr_data = 8'h01;
      @(posedge clk); #1;
      check("R10 tc over enable write", chan_en[ch], 0);
      @(negedge clk); tc_in = '0; wr_byte = 0;
      @(posedge clk); #1;
      m_fl[ch] = 1;
      do_read(ch);
    end

    for (int ch = 0; ch < N; ch++)
      for (int st = 0; st < 4; st++)
        for (int v = 0; v < 256; v++) begin
          set_state(ch, st);
          do_byte(ch, v[7:0]);
          do_read(ch);
        end

    for (int ch = 0; ch < N; ch++)
      for (int st = 0; st < 4; st++)
        for (int idx = 0; idx < 8; idx++)
          for (int val = 0; val < 2; val++) begin
            set_state(ch, st);
            do_bit(ch, idx, val[0]);
            do_read(ch);
          end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog R1 actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule